// File: doc/BRIEF.md
# Management Serial Bus Master (Clause 22 / Clause 45)

This block drives the two-wire Ethernet management bus that configures PHY devices. Software programs it through a small register window: it loads a 16-bit address and a 16-bit write value, then writes a command word. The command word holds the target port and device or register number, an opcode, a framing selector and a start bit. When the start bit is written as 1 while the block is idle, the block sends one complete management frame on the bus.

Frames run at a management clock derived from the system clock by a fixed divider. The block drives the data pin and its output enable, and it samples the incoming data pin during reads. When the frame ends, the start bit clears. For a read, the block captures the 16 returned bits and records whether the PHY answered. Clause 45 transactions that need an address frame and then a data frame are sequenced by software as two commands. The block keeps its address copy current on read-with-increment.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The register window uses these byte offsets: command at 0x0, clause 45 address at 0x4, write data at 0x8, read data at 0xC, status at 0x10. Every register reads 0 after reset.
- R2: The command word has this layout: start in bit 14, framing selector in [13:12], opcode in [11:10], port in [9:5], device or register in [4:0]. Writing it with bit 14 set while idle starts a frame. Start then reads 1 until the frame's final MDC falling edge and reads 0 afterwards.
- R3: A frame has 64 bits, sent MSB first, each presented at the MDC falling edge. The bits are 32 ones, then the two selector bits, the two opcode bits, five port bits, five device bits, turnaround 1 then 0, and 16 data bits. On a write, the output enable is high for all 64 bits.
- R4: MDC is low while idle. During a frame its period is 2*HALF_DIV system clocks, with 64 rising edges per frame.
- R5: The data field of a frame carries the address register when the selector is 0 and the opcode is 0 (clause 45 address frame). On every other write it carries the write-data register.
- R6: A frame is a read when the selector is 1 with opcode 2, or the selector is 0 with opcode 2 or 3. On a read, the output enable drops from bit 46 (the first turnaround bit) onward. The 16 data bits are sampled at MDC rising edges, MSB first, into the read-data register.
- R7: After a read, status bit 0 is 1 if MDIO was high at the rising edge of the second turnaround bit (bit 47), and 0 otherwise.
- R8: A selector-0, opcode-2 frame (read with post-increment) adds 1 to the address register when the frame ends. A selector-0, opcode-3 read leaves it unchanged.
- R9: Writes to the command register while start reads 1 are ignored: they change no field and begin no frame.
- R10: MDIO output enable is low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Register read value for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the data pin |
| mdio_i | input | 1 | Management data in |

## Verification
A responding PHY model records every bit at each MDC rising edge and plays back turnaround and data bits. Each frame type is issued with its own port, device and data values: clause 22 write and read, and clause 45 address, write, read-increment and plain read. This shows that the selector and opcode bits land in the right positions, and that the data field comes from the address register or the write register as required. Running reads with the second turnaround bit pulled low and then left high separates a good read from a failed one. Running read-increment next to a plain read shows that only the first one changes the address. A command rewritten in mid-frame must leave both the frame on the wire and the command readback untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = 64;
  localparam int DRIVE_RD   = 46;  // bits driven by master on a read
  localparam int TA2_BIT    = 47;
  localparam int DATA_BIT0  = 48;

  localparam logic [4:0] OFS_CMD   = 5'h00;
  localparam logic [4:0] OFS_ADDR  = 5'h04;
  localparam logic [4:0] OFS_WDATA = 5'h08;
  localparam logic [4:0] OFS_RDATA = 5'h0C;
  localparam logic [4:0] OFS_STAT  = 5'h10;
  localparam int START_BIT = 14;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] op;
    logic [4:0] port;
    logic [4:0] dev;
  } mgmt_cmd_t;

  function automatic logic cmd_is_read(mgmt_cmd_t c);
    return (c.sel == 2'd1) ? (c.op == 2'd2) : c.op[1];
  endfunction

  function automatic logic cmd_uses_addr(mgmt_cmd_t c);
    return (c.sel == 2'd0) && (c.op == 2'd0);
  endfunction

  function automatic logic cmd_post_inc(mgmt_cmd_t c);
    return (c.sel == 2'd0) && (c.op == 2'd2);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_cmd_t c,
                                                        logic [DATA_W-1:0] d);
    return {32'hFFFF_FFFF, c.sel, c.op, c.port, c.dev, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == LAST);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  mgmt_cmd_t         cmd,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              run,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              rd_frame,
  output logic [5:0]        bit_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              ta_err
);
  logic [FRAME_BITS-1:0] shreg;
  logic [6:0]            nxt_idx;

  assign nxt_idx = {1'b0, bit_idx} + 7'd1;
  assign done    = run && fall && (bit_idx == 6'd63);
  assign mdio_o  = mdio_oe && shreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      shreg    <= '0;
      bit_idx  <= '0;
      rd_frame <= 1'b0;
      mdio_oe  <= 1'b0;
      rd_data  <= '0;
      ta_err   <= 1'b0;
    end else if (go) begin
      run      <= 1'b1;
      shreg    <= build_frame(cmd, tx_data);
      bit_idx  <= '0;
      rd_frame <= cmd_is_read(cmd);
      mdio_oe  <= 1'b1;
      ta_err   <= 1'b0;
    end else if (run) begin
      if (fall) begin
        if (bit_idx == 6'd63) begin
          run     <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
          bit_idx <= nxt_idx[5:0];
          mdio_oe <= rd_frame ? (nxt_idx < 7'(DRIVE_RD)) : 1'b1;
        end
      end
      if (rise && rd_frame) begin
        if (bit_idx == 6'(TA2_BIT)) ta_err <= mdio_i;
        if (bit_idx >= 6'(DATA_BIT0)) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mgmt_cmd_t         cmd_q, cmd_new;
  logic              start_q;
  logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
  logic              err_q;

  // named events for the checker
  logic              cmd_wr, addr_wr, go, frame_done, busy, inc_on_done;
  logic              clk_run, mdc_rise, mdc_fall, rd_frame, ta_err;
  logic [5:0]        bit_idx;
  logic [DATA_W-1:0] rx_data, tx_data;

  assign cmd_new     = mgmt_cmd_t'(reg_wdata[13:0]);
  assign cmd_wr      = reg_we && (reg_addr == OFS_CMD) && !start_q;
  assign addr_wr     = reg_we && (reg_addr == OFS_ADDR);
  assign go          = cmd_wr && reg_wdata[START_BIT];
  assign busy        = start_q;
  assign inc_on_done = frame_done && cmd_post_inc(cmd_q);
  assign tx_data     = cmd_uses_addr(cmd_new) ? addr_q : wdata_q;

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(clk_run),
    .mdc(mdc), .rise(mdc_rise), .fall(mdc_fall)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd(cmd_new), .tx_data(tx_data),
    .rise(mdc_rise), .fall(mdc_fall), .mdio_i(mdio_i),
    .run(clk_run), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(frame_done),
    .rd_frame(rd_frame), .bit_idx(bit_idx), .rd_data(rx_data), .ta_err(ta_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (cmd_wr) begin
        cmd_q   <= cmd_new;
        start_q <= reg_wdata[START_BIT];
      end else if (frame_done) begin
        start_q <= 1'b0;
      end
      if (reg_we && reg_addr == OFS_WDATA) wdata_q <= reg_wdata;
      if (addr_wr)          addr_q <= reg_wdata;
      else if (inc_on_done) addr_q <= addr_q + 1'b1;
      if (frame_done && rd_frame) begin
        rdata_q <= rx_data;
        err_q   <= ta_err;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CMD:   reg_rdata = {1'b0, start_q, cmd_q};
      OFS_ADDR:  reg_rdata = addr_q;
      OFS_WDATA: reg_rdata = wdata_q;
      OFS_RDATA: reg_rdata = rdata_q;
      OFS_STAT:  reg_rdata = {15'd0, err_q};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        frame_done,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        rd_frame,
  input logic [5:0]  bit_idx,
  input logic [13:0] cmd_word,
  input logic [15:0] addr_q,
  input logic        inc_on_done,
  input logic        addr_wr
);
  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !frame_done |=> busy); // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy); // R2
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R4
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_frame && (bit_idx >= 6'd46) |-> !mdio_oe); // R6
  AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
    inc_on_done && !addr_wr |=> addr_q == $past(addr_q) + 16'd1); // R8
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !frame_done |=> $stable(cmd_word)); // R9
  AST_IDLE_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R10
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .frame_done(frame_done),
  .mdc(mdc), .mdio_oe(mdio_oe), .rd_frame(rd_frame), .bit_idx(bit_idx),
  .cmd_word(cmd_q), .addr_q(addr_q), .inc_on_done(inc_on_done),
  .addr_wr(addr_wr)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;

  // PHY responder state
  int          rise_cnt = 0;
  int          base = 0;
  logic [63:0] cap_o, cap_oe, resp;

  always #10 clk = ~clk;

  mdio_mgmt_master #(.HALF_DIV(HALF)) u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    int k;
    k = rise_cnt - base;
    if (k >= 0 && k < 64) begin
      cap_o[63-k]  = mdio_o;
      cap_oe[63-k] = mdio_oe;
    end
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc) begin
    int k;
    k = rise_cnt - base;
    mdio_i = (k >= 0 && k < 64) ? resp[63-k] : 1'b1;
  end

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] cmd_word(logic [1:0] sel, logic [1:0] op,
                                           logic [4:0] port, logic [4:0] dev);
    return {1'b0, 1'b1, sel, op, port, dev};
  endfunction

  function automatic logic [63:0] exp_frame(logic [1:0] sel, logic [1:0] op,
      logic [4:0] port, logic [4:0] dev, logic [15:0] d);
    logic [63:0] f;
    f = '1;
    f[31:30] = sel; f[29:28] = op; f[27:23] = port; f[22:18] = dev;
    f[17:16] = 2'b10; f[15:0] = d;
    return f;
  endfunction

  task automatic set_resp(logic ta_low, logic [15:0] d);
    resp = '1;
    resp[16] = !ta_low;
    resp[15:0] = d;
  endtask

  task automatic wait_idle(string req);
    logic [15:0] v;
    int guard;
    guard = 0;
    do begin
      bus_rd(5'h00, v);
      guard++;
    end while (v[14] && guard < 2000);
    check(req, 64'(v[14]), 64'd0);
  endtask

  task automatic issue(logic [15:0] cmd);
    base = rise_cnt;
    bus_wr(5'h00, cmd);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int i = 0; i < 5; i++) begin
      bus_rd(5'(4*i), v);
      check("R1 reset value", 64'(v), 64'd0);
    end
    check("R4 mdc idle low", 64'(mdc), 64'd0);
    check("R10 oe idle low", 64'(mdio_oe), 64'd0);
  endtask

  task automatic t_c22_write;
    logic [15:0] v;
    bus_wr(5'h08, 16'hA5C3);
    set_resp(1'b1, 16'h0000);
    issue(cmd_word(2'd1, 2'd1, 5'h13, 5'h0A));
    bus_rd(5'h00, v);
    check("R2 start reads 1 in frame", 64'(v[14]), 64'd1);
    wait_idle("R2 start clears");
    check("R3 c22 write frame", cap_o, exp_frame(2'd1, 2'd1, 5'h13, 5'h0A, 16'hA5C3));
    check("R3 write oe all bits", cap_oe, '1);
    check("R4 64 mdc rises", 64'(rise_cnt - base), 64'd64);
    check("R10 oe low after frame", 64'(mdio_oe), 64'd0);
  endtask

  task automatic t_c22_read(logic ta_low, logic [15:0] d);
    logic [15:0] v;
    logic [63:0] m;
    m = {{46{1'b1}}, 18'd0};
    set_resp(ta_low, d);
    issue(cmd_word(2'd1, 2'd2, 5'h01, 5'h1F));
    wait_idle("R2 start clears");
    check("R6 c22 read header", cap_o & m,
          exp_frame(2'd1, 2'd2, 5'h01, 5'h1F, 16'h0) & m);
    check("R6 read oe release", cap_oe, m);
    bus_rd(5'h10, v);
    check("R7 read status", 64'(v[0]), 64'(!ta_low));
    if (ta_low) begin
      bus_rd(5'h0C, v);
      check("R6 read data", 64'(v), 64'(d));
    end
  endtask

  task automatic t_c45_addr_write;
    bus_wr(5'h04, 16'hBEEF);
    bus_wr(5'h08, 16'h1357);
    issue(cmd_word(2'd0, 2'd0, 5'h07, 5'h03));
    wait_idle("R2 start clears");
    check("R5 c45 address frame carries address", cap_o,
          exp_frame(2'd0, 2'd0, 5'h07, 5'h03, 16'hBEEF));
    issue(cmd_word(2'd0, 2'd1, 5'h07, 5'h03));
    wait_idle("R2 start clears");
    check("R5 c45 write frame carries write data", cap_o,
          exp_frame(2'd0, 2'd1, 5'h07, 5'h03, 16'h1357));
  endtask

  task automatic t_c45_reads;
    logic [15:0] v;
    bus_wr(5'h04, 16'h00FF);
    set_resp(1'b1, 16'hC0DE);
    issue(cmd_word(2'd0, 2'd2, 5'h02, 5'h01));
    wait_idle("R2 start clears");
    bus_rd(5'h04, v);
    check("R8 post-increment address", 64'(v), 64'h0100);
    bus_rd(5'h0C, v);
    check("R6 c45 read data", 64'(v), 64'hC0DE);
    check("R6 c45 increment read oe", cap_oe, {{46{1'b1}}, 18'd0});
    set_resp(1'b1, 16'h4242);
    issue(cmd_word(2'd0, 2'd3, 5'h02, 5'h01));
    wait_idle("R2 start clears");
    bus_rd(5'h04, v);
    check("R8 plain read keeps address", 64'(v), 64'h0100);
    bus_rd(5'h0C, v);
    check("R6 c45 plain read data", 64'(v), 64'h4242);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] v;
    logic [15:0] c0;
    c0 = cmd_word(2'd1, 2'd1, 5'h0C, 5'h05);
    bus_wr(5'h08, 16'h6E6E);
    issue(c0);
    repeat (20) @(negedge clk);
    bus_wr(5'h00, cmd_word(2'd0, 2'd2, 5'h1A, 5'h11));
    wait_idle("R2 start clears");
    check("R9 frame unchanged by busy write", cap_o,
          exp_frame(2'd1, 2'd1, 5'h0C, 5'h05, 16'h6E6E));
    bus_rd(5'h00, v);
    check("R9 command fields kept", 64'(v[13:0]), 64'(c0[13:0]));
    repeat (4 * HALF) @(negedge clk);
    check("R9 no second frame", 64'(mdio_oe | mdc), 64'd0);
  endtask

  task automatic t_mdc_period;
    realtime t0, t1;
    set_resp(1'b1, 16'h0);
    issue(cmd_word(2'd1, 2'd1, 5'h00, 5'h00));
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    check("R4 mdc period ns", 64'(int'(t1 - t0)), 64'(2 * HALF * 20));
    wait_idle("R2 start clears");
  endtask

  initial begin
    set_resp(1'b1, 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_c22_write();
    t_c22_read(1'b1, 16'h1234);
    t_c22_read(1'b0, 16'h5678);
    t_c45_addr_write();
    t_c45_reads();
    t_busy_ignore();
    t_mdc_period();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule